// File: doc/BRIEF.md
# Trace Data Nibble Serializer

This block turns captured processor events into a narrow debug trace stream. Two kinds of record enter it: operand accesses (a strobe with a read/write flag, a size code and 32 bits of data) and taken-branch events (a strobe with a 32-bit target address). A two-bit capture-control field picks which operand accesses are kept: none, writes only, reads only, or both. A two-bit target-length field picks how many low bytes of each branch target are kept: none, two, three or four. Each kept record carries only as many nibbles as its size calls for, and the records leave on a 4-bit data bus one nibble per clock, least significant nibble first, with a valid flag marking the nibbles.

Kept records wait in a four-entry queue and leave in arrival order. When an operand access and a branch arrive in the same cycle, the operand record is queued first. A record that finds the queue full is thrown away, and a sticky overflow flag goes high until reset. Both control fields act when a record is queued, so changing them later does not alter records already waiting.

The output side is a two-state machine. IDLE: nothing is sent, the bus is zero and valid is low; on a non-empty queue it takes the head record (transition LOAD) and moves to SHIFT. SHIFT: one nibble goes out each cycle. On the last nibble of a record it either takes the next record at once and stays in SHIFT (transition RELOAD), so records follow with no gap, or, with an empty queue, returns to IDLE (transition DRAIN).

Top module: `trc_nibble_serializer`

## Requirements
- R1: Operand capture follows `cap_mode`: 2'b00 keeps no access, 2'b01 keeps only writes (`acc_write`=1), 2'b10 keeps only reads (`acc_write`=0), 2'b11 keeps both. A dropped access produces no nibble.
- R2: A kept operand record sends 2 nibbles for `acc_size`=2'b00 (byte), 4 for 2'b01 (word), and 8 for 2'b10 or 2'b11 (longword), taken from the low end of `acc_data`.
- R3: A branch record sends the low 4 nibbles of `br_target` for `tgt_bytes`=2'b01, the low 6 for 2'b10, all 8 for 2'b11; with 2'b00 the branch queues nothing.
- R4: Each record is sent least significant nibble first (bits 3:0, then 7:4, and so on), one nibble per clock on consecutive cycles.
- R5: Records leave in arrival order; an operand record and a branch record arriving in the same cycle leave operand first. The queue holds 4 records besides the one being sent, so eight longword records arriving on eight consecutive cycles into an idle block keep the first five.
- R6: A record arriving while the queue is full is discarded, and `ovf` rises and stays high until reset; later records are still accepted once room appears.
- R7: `tvalid` is high only on cycles carrying a record nibble, and `tdata` is 4'h0 on every cycle with `tvalid` low.
- R8: A record strobed into an idle, empty block shows its first nibble in the second cycle after the strobe cycle; the next queued record's first nibble follows the previous record's last nibble on the very next cycle.
- R9: After reset `tvalid`=0, `tdata`=4'h0 and `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_mode | input | 2 | Operand capture selection (R1) |
| tgt_bytes | input | 2 | Branch target length selection (R3) |
| acc_valid | input | 1 | Operand access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_size | input | 2 | Access size: 00 byte, 01 word, 1x longword |
| acc_data | input | 32 | Operand data |
| br_valid | input | 1 | Branch strobe, one cycle per branch |
| br_target | input | 32 | Branch target address |
| tdata | output | 4 | Trace nibble |
| tvalid | output | 1 | High when `tdata` carries a record nibble |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions take the strobes to be known (never X) from reset onward, since the start-latency property looks two cycles back at `acc_valid` and `br_valid` and the overflow-cause property one cycle back. They also assume the queue can only be popped by the output machine, so its occupancy never exceeds four. The bench holds every strobe low through reset, drives inputs one time unit after a rising edge as single-cycle pulses, and samples on the falling edge, so no input is ever unknown or changing at a sampling edge.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int DW   = 32;   // record payload width
    localparam int NW   = 4;    // nibble width on the trace bus
    localparam int CNTW = 4;    // nibble counter width, holds DW/NW

    typedef struct packed {
        logic [DW-1:0]   data;
        logic [CNTW-1:0] nnib;
    } trc_rec_t;

    // Nibbles carried by an operand access of a given size code.
    function automatic logic [CNTW-1:0] op_nibbles(input logic [1:0] sz);
        logic [CNTW-1:0] n;
        case (sz)
            2'b00:   n = CNTW'(2);
            2'b01:   n = CNTW'(4);
            default: n = CNTW'(DW / NW);
        endcase
        return n;
    endfunction

    // Nibbles carried by a branch target for a given length code.
    function automatic logic [CNTW-1:0] br_nibbles(input logic [1:0] tb);
        logic [CNTW-1:0] n;
        case (tb)
            2'b01:   n = CNTW'(4);
            2'b10:   n = CNTW'(6);
            2'b11:   n = CNTW'(DW / NW);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/trc_filter.sv
module trc_filter
    import trc_pkg::*;
(
    input  logic          [1:0]  cap_mode,
    input  logic          [1:0]  tgt_bytes,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic          [1:0]  acc_size,
    input  logic [DW-1:0]        acc_data,
    input  logic                 br_valid,
    input  logic [DW-1:0]        br_target,
    output logic                 op_v,
    output trc_rec_t             op_rec,
    output logic                 br_v,
    output trc_rec_t             br_rec
);

    // cap_mode bit 0 admits writes, bit 1 admits reads
    always_comb begin
        op_v        = acc_valid && (acc_write ? cap_mode[0] : cap_mode[1]);
        op_rec.data = acc_data;
        op_rec.nnib = op_nibbles(acc_size);
        br_v        = br_valid && (tgt_bytes != 2'b00);
        br_rec.data = br_target;
        br_rec.nnib = br_nibbles(tgt_bytes);
    end

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
    import trc_pkg::*;
#(
    parameter  int DEPTH = 4,               // power of two
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in0_v,
    input  trc_rec_t      in0,
    input  logic          in1_v,
    input  trc_rec_t      in1,
    input  logic          pop,
    output trc_rec_t      head,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          drop
);

    localparam logic [CW:0] DEPTH_W = (CW + 1)'(DEPTH);

    trc_rec_t        mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic            a0, a1;

    // Room is judged on the registered count; a same-cycle pop gives no credit.
    always_comb begin
        a0    = in0_v && ({1'b0, count} < DEPTH_W);
        a1    = in1_v && (({1'b0, count} + (CW + 1)'(a0)) < DEPTH_W);
        drop  = (in0_v && !a0) || (in1_v && !a1);
        empty = (count == '0);
        head  = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (a0)
            mem[wp] <= in0;
        if (a1)
            mem[a0 ? wp + PW'(1) : wp] <= in1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PW'(a0) + PW'(a1);
            rp    <= rp + PW'(pop);
            count <= count + CW'(a0) + CW'(a1) - CW'(pop);
        end
    end

endmodule

// File: rtl/trc_shifter.sv
module trc_shifter
    import trc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avail,
    input  trc_rec_t      head,
    output logic          pop,
    output logic [NW-1:0] tdata,
    output logic          tvalid
);

    typedef enum logic {ST_IDLE, ST_SHIFT} st_e;

    st_e             state, nxt;
    logic [DW-1:0]   shreg;
    logic [CNTW-1:0] cnt;
    logic            last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Next state: LOAD, RELOAD, DRAIN
    always_comb begin
        last = (cnt == CNTW'(1));
        nxt  = state;
        pop  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (avail) begin
                    pop = 1'b1;
                    nxt = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    if (avail)
                        pop = 1'b1;
                    else
                        nxt = ST_IDLE;
                end
            end
        endcase
    end

    // Shift register and nibble counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (pop) begin
            shreg <= head.data;
            cnt   <= head.nnib;
        end else if (state == ST_SHIFT) begin
            shreg <= shreg >> NW;
            cnt   <= cnt - CNTW'(1);
        end
    end

    // Outputs
    always_comb begin
        tvalid = (state == ST_SHIFT);
        tdata  = tvalid ? shreg[NW-1:0] : '0;
    end

endmodule

// File: rtl/trc_nibble_serializer.sv
module trc_nibble_serializer
    import trc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cap_mode,
    input  logic [1:0]  tgt_bytes,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_data,
    input  logic        br_valid,
    input  logic [31:0] br_target,
    output logic [3:0]  tdata,
    output logic        tvalid,
    output logic        ovf
);

    logic          op_v, br_v, pop, empty, drop;
    trc_rec_t      op_rec, br_rec, head;
    logic [CW-1:0] fifo_count;

    trc_filter u_filter (
        .cap_mode  (cap_mode),
        .tgt_bytes (tgt_bytes),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_data  (acc_data),
        .br_valid  (br_valid),
        .br_target (br_target),
        .op_v      (op_v),
        .op_rec    (op_rec),
        .br_v      (br_v),
        .br_rec    (br_rec)
    );

    // Operand record takes the first slot when both arrive together
    trc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .in0_v (op_v),
        .in0   (op_rec),
        .in1_v (br_v),
        .in1   (br_rec),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .count (fifo_count),
        .drop  (drop)
    );

    trc_shifter u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .avail  (!empty),
        .head   (head),
        .pop    (pop),
        .tdata  (tdata),
        .tvalid (tvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
    end

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          br_valid,
    input logic [3:0]    tdata,
    input logic          tvalid,
    input logic          ovf,
    input logic [CW-1:0] fifo_count
);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tvalid |-> (tdata == 4'h0))
        else $error("idle bus not zero");

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf)
        else $error("overflow flag cleared without reset");

    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(acc_valid || br_valid))
        else $error("overflow without an arriving record");

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH))
        else $error("queue occupancy beyond depth");

    p_start_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tvalid) |-> $past(acc_valid || br_valid, 2))
        else $error("stream started without a strobe two cycles earlier");

endmodule

bind trc_nibble_serializer trc_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .br_valid   (br_valid),
    .tdata      (tdata),
    .tvalid     (tvalid),
    .ovf        (ovf),
    .fifo_count (fifo_count)
);

// File: tb/tb_trc_nibble_serializer.sv
module tb_trc_nibble_serializer;

    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cap_mode = 2'b11;
    logic [1:0]  tgt_bytes = 2'b11;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic [31:0] acc_data = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_target = '0;
    logic [3:0]  tdata;
    logic        tvalid;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    int idle_bad = 0;
    logic [3:0] got[$];
    logic [3:0] exp[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    trc_nibble_serializer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_mode  (cap_mode),
        .tgt_bytes (tgt_bytes),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_data  (acc_data),
        .br_valid  (br_valid),
        .br_target (br_target),
        .tdata     (tdata),
        .tvalid    (tvalid),
        .ovf       (ovf)
    );

    // Stream collector, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tvalid)
                got.push_back(tdata);
            else if (tdata !== 4'h0)
                idle_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int op_len(input logic [1:0] sz);
        if (sz == 2'b00) return 2;
        if (sz == 2'b01) return 4;
        return 8;
    endfunction

    function automatic int br_len(input logic [1:0] tb);
        if (tb == 2'b01) return 4;
        if (tb == 2'b10) return 6;
        if (tb == 2'b11) return 8;
        return 0;
    endfunction

    task automatic add_exp(input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++)
            exp.push_back(d[4*i +: 4]);
    endtask

    // One input cycle; strobes return low after it
    task automatic pulse(input bit av, input bit aw, input logic [1:0] sz,
                         input logic [31:0] ad, input bit bv, input logic [31:0] bt);
        acc_valid = av; acc_write = aw; acc_size = sz; acc_data = ad;
        br_valid = bv; br_target = bt;
        @(posedge clk); #1;
        acc_valid = 1'b0; br_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (60) @(posedge clk);
        #1;
    endtask

    task automatic check_stream(input string req, input string what);
        bit ok = (got.size() == exp.size());
        int idx = -1;
        if (ok) begin
            for (int i = 0; i < got.size(); i++)
                if (got[i] !== exp[i] && idx < 0) idx = i;
            ok = (idx < 0);
        end
        if (!ok && idx >= 0)
            chk(ok, req, $sformatf("%s nibble %0d", what, idx), 64'(got[idx]), 64'(exp[idx]));
        else
            chk(ok, req, {what, " nibble count"}, 64'(got.size()), 64'(exp.size()));
        got.delete();
        exp.delete();
    endtask

    task automatic t_reset();
        chk(tvalid === 1'b0 && tdata === 4'h0 && ovf === 1'b0, "R9", "reset outputs",
            {59'd0, ovf, tvalid, tdata[2:0]}, 64'd0);
    endtask

    task automatic t_filter(input logic [1:0] mode);
        logic [31:0] rd = 32'hA1B2_C3D4 ^ {30'd0, mode};
        logic [31:0] wr = 32'h5E6F_7081 ^ {30'd0, mode};
        cap_mode = mode;
        pulse(1'b1, 1'b0, 2'b10, rd, 1'b0, '0);
        if (mode[1]) add_exp(rd, 8);
        pulse(1'b1, 1'b1, 2'b10, wr, 1'b0, '0);
        if (mode[0]) add_exp(wr, 8);
        drain();
        check_stream("R1", $sformatf("cap_mode=%0d", mode));
        cap_mode = 2'b11;
    endtask

    task automatic t_sizes();
        for (int s = 0; s < 4; s++) begin
            logic [31:0] d = 32'h9876_5432 + 32'(s) * 32'h0101_0101;
            pulse(1'b1, s[0], 2'(s), d, 1'b0, '0);
            add_exp(d, op_len(2'(s)));
            drain();
            check_stream("R2", $sformatf("size=%0d", s));
        end
    endtask

    task automatic t_branch();
        for (int b = 0; b < 4; b++) begin
            logic [31:0] t = 32'hCAFE_1234 + 32'(b);
            tgt_bytes = 2'(b);
            pulse(1'b0, 1'b0, 2'b00, '0, 1'b1, t);
            add_exp(t, br_len(2'(b)));
            drain();
            check_stream("R3", $sformatf("tgt_bytes=%0d", b));
        end
        tgt_bytes = 2'b11;
    endtask

    task automatic t_same_cycle();
        tgt_bytes = 2'b10;
        pulse(1'b1, 1'b1, 2'b01, 32'h0000_BEEF, 1'b1, 32'h0012_3456);
        add_exp(32'h0000_BEEF, 4);
        add_exp(32'h0012_3456, 6);
        drain();
        check_stream("R5", "operand before branch");
        tgt_bytes = 2'b11;
    endtask

    // Cycle-exact start and back-to-back records
    task automatic t_latency();
        logic [3:0] want[4] = '{4'hC, 4'h3, 4'h6, 4'h9};
        acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'b00; acc_data = 32'h3C;
        @(negedge clk);
        chk(tvalid === 1'b0, "R8", "valid in strobe cycle", 64'(tvalid), 64'd0);
        @(posedge clk); #1;
        acc_data = 32'h96;
        @(negedge clk);
        chk(tvalid === 1'b0, "R8", "valid one cycle after strobe", 64'(tvalid), 64'd0);
        @(posedge clk); #1;
        acc_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(tvalid === 1'b1 && tdata === want[i], "R4", $sformatf("lsn-first nibble %0d", i),
                {59'd0, tvalid, tdata}, {59'd0, 1'b1, want[i]});
        end
        @(negedge clk);
        chk(tvalid === 1'b0 && tdata === 4'h0, "R7", "idle after stream",
            {59'd0, tvalid, tdata}, 64'd0);
        drain();
        got.delete();
        exp.delete();
    endtask

    task automatic t_overflow();
        chk(ovf === 1'b0, "R6", "ovf before burst", 64'(ovf), 64'd0);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] d = 32'h7654_3210 + 32'(k) * 32'h1111_1111;
            pulse(1'b1, 1'b1, 2'b10, d, 1'b0, '0);
            if (k < 5) add_exp(d, 8);
        end
        drain();
        check_stream("R5", "burst keeps first five");
        chk(ovf === 1'b1, "R6", "ovf after burst", 64'(ovf), 64'd1);
        pulse(1'b1, 1'b0, 2'b01, 32'h0000_4D2E, 1'b0, '0);
        add_exp(32'h0000_4D2E, 4);
        drain();
        check_stream("R6", "record accepted after overflow");
        chk(ovf === 1'b1, "R6", "ovf stays set", 64'(ovf), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        for (int m = 0; m < 4; m++)
            t_filter(2'(m));
        t_sizes();
        t_branch();
        t_same_cycle();
        t_latency();
        t_overflow();
        chk(idle_bad == 0, "R7", "idle cycles with nonzero bus", 64'(idle_bad), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule